// File: doc/BRIEF.md
# Handshake Peripheral Bus to Core Wrapper

This block sits between a lightweight synchronous peripheral bus and the internal interface of a peripheral core. The bus has no fixed minimum access length. The master puts up an address and a read or write strobe, then waits for a ready pulse that ends the access. Inside, the core sees a valid/acknowledge handshake, a read flag, and separate one-way write-data and read-data buses.

Each access moves through four registered steps. The first clock captures the bus request. The second raises valid toward the core. The third is the core's acknowledge, which carries the read data. The fourth pulses bus ready, with read data on the bus. A core that answers at once therefore gives a four-cycle read, against two cycles for a core wired straight to the bus. That cost shows on reads. Writes finish in the same number of cycles, but the master has no data to wait for.

Once the wrapper has captured a request, it ignores the bus until that handshake is over. A strobe that is still high after ready does not start a second access. The master has to drop the strobe first.

Top module: `hs_bus_wrapper`

## Requirements
- R1: While reset is high, and in the first cycle after reset, bus_rdy and core_val are 0.
- R2: For a read (bus_rd=1), bus_rdy is high in the 4th clock cycle after the strobe is first sampled, provided the core acknowledges in the cycle after valid rises. Each extra cycle the core waits before acknowledging adds one cycle.
- R3: In the cycle bus_rdy is high for a read, bus_rdata equals the core_rdata value that was present with core_ack.
- R4: For a write (bus_wr=1, bus_rd=0), the core sees core_rd=0, together with the bus address and write data, while core_val is high. bus_rdy follows one cycle after the acknowledge, so a write has the same 4-cycle timing as a read.
- R5: core_val stays high until core_ack is seen. core_addr, core_wdata and core_rd do not change while valid waits for that acknowledge.
- R6: bus_rdy is a one-cycle pulse, and each access produces exactly one pulse.
- R7: A strobe held high after bus_rdy starts no new access. core_val and bus_rdy stay 0 until the strobe has been low for at least one cycle.
- R8: Changes to bus_addr, bus_wdata or the strobes after a request has been captured have no effect on the transfer in flight. The core receives the captured address, and the read returns that address's data.
- R9: When a write completes, bus_rdata keeps the value of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rd | input | 1 | Read strobe (wins over bus_wr) |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Bus read data, registered |
| bus_rdy | output | 1 | One-cycle ready that ends an access |
| core_val | output | 1 | Request valid to core |
| core_rd | output | 1 | 1 = read, 0 = write |
| core_addr | output | ADDR_W | Captured address to core |
| core_wdata | output | DATA_W | Captured write data to core |
| core_rdata | input | DATA_W | Read data from core, valid with core_ack |
| core_ack | input | 1 | Core acknowledge |

## Verification
Two events can fall in the same cycle: the core's acknowledge is closing a transfer while the master changes the bus address, data or strobe. The bench sets up this collision in two ways. It holds the core off for several cycles and rewrites the bus inputs during the wait and at the acknowledge edge. It also keeps the strobe high past ready. The outcome is judged by the scoreboard's expected data for the originally captured address, by the address the core model records at its acknowledge, and by the absence of any further valid or ready while the strobe stays high.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } wrp_state_t;
endpackage

// File: rtl/wrp_req_reg.sv
module wrp_req_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_rd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_addr  <= '0;
      req_wdata <= '0;
      req_rd    <= 1'b0;
    end else if (capture) begin
      req_addr  <= in_addr;
      req_wdata <= in_wdata;
      req_rd    <= in_rd;
    end
  end
endmodule

// File: rtl/wrp_seq.sv
module wrp_seq
  import wrp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic core_ack,
  output logic capture,
  output logic take,
  output logic core_val,
  output logic bus_rdy
);
  wrp_state_t state;
  logic       armed;
  logic       strobe;

  assign strobe  = bus_rd | bus_wr;
  assign capture = (state == ST_IDLE) && strobe && armed;
  assign take    = (state == ST_WAIT) && core_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      core_val <= 1'b0;
      bus_rdy  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      bus_rdy <= 1'b0;
      if (!strobe) armed <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (capture) begin
            state <= ST_ISSUE;
            armed <= 1'b0;
          end
        end
        ST_ISSUE: begin
          core_val <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (core_ack) begin
            core_val <= 1'b0;
            bus_rdy  <= 1'b1;
            state    <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_val_holds_R5: assert property (@(posedge clk) disable iff (rst)
    core_val && !core_ack |=> core_val);
  assert_rdy_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
    core_val && core_ack |=> bus_rdy);
  assert_rdy_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    bus_rdy |=> !bus_rdy);
  assert_rdy_not_with_val_R6: assert property (@(posedge clk) disable iff (rst)
    bus_rdy |-> !core_val);
endmodule

// File: rtl/wrp_rdpath.sv
module wrp_rdpath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (load) bus_rdata <= core_rdata;
  end
endmodule

// File: rtl/hs_bus_wrapper.sv
module hs_bus_wrapper #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdy,
  output logic              core_val,
  output logic              core_rd,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              core_ack
);
  logic capture;
  logic take;

  wrp_seq i_seq (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .core_ack(core_ack), .capture(capture), .take(take),
    .core_val(core_val), .bus_rdy(bus_rdy)
  );

  wrp_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_req (
    .clk(clk), .rst(rst), .capture(capture),
    .in_addr(bus_addr), .in_wdata(bus_wdata), .in_rd(bus_rd),
    .req_addr(core_addr), .req_wdata(core_wdata), .req_rd(core_rd)
  );

  wrp_rdpath #(.DATA_W(DATA_W)) i_rd (
    .clk(clk), .rst(rst), .load(take && core_rd),
    .core_rdata(core_rdata), .bus_rdata(bus_rdata)
  );

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (rst)
    core_val && !core_ack |=> $stable(core_addr) && $stable(core_wdata) && $stable(core_rd));
  assert_read_data_R3: assert property (@(posedge clk) disable iff (rst)
    core_val && core_ack && core_rd |=> bus_rdy && (bus_rdata == $past(core_rdata)));
  assert_write_keeps_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rdy && !core_rd |-> $stable(bus_rdata));
endmodule

// File: tb/test_hs_bus_wrapper.sv
module test_hs_bus_wrapper;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int MEM_N  = 16;

  typedef struct {
    bit              rd;
    logic [DATA_W-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic bus_rdy, core_val, core_rd;
  logic [ADDR_W-1:0] core_addr;
  logic [DATA_W-1:0] core_wdata;
  logic [DATA_W-1:0] core_rdata;
  logic core_ack;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];
  logic [DATA_W-1:0] mem [MEM_N];
  logic [DATA_W-1:0] shadow [MEM_N];
  logic [DATA_W-1:0] last_rd = '0;
  int core_delay = 0;
  int wait_cnt = 0;
  logic [ADDR_W-1:0] ack_addr = '0;
  logic prev_rdy = 1'b0;

  always #10 clk = ~clk;

  hs_bus_wrapper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hs_bus_wrapper (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .core_val(core_val), .core_rd(core_rd), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ack(core_ack)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // core model: acks after core_delay waiting cycles, registered
  always @(posedge clk) begin
    if (rst) begin
      core_ack <= 1'b0;
      core_rdata <= '0;
      wait_cnt <= 0;
    end else if (core_val && !core_ack && wait_cnt == core_delay) begin
      core_ack <= 1'b1;
      core_rdata <= mem[core_addr[3:0]];
      ack_addr <= core_addr;
      if (!core_rd) mem[core_addr[3:0]] <= core_wdata;
      wait_cnt <= 0;
    end else begin
      core_ack <= 1'b0;
      if (core_val && !core_ack) wait_cnt <= wait_cnt + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rdy && prev_rdy) check(1'b0, "R6 ready longer than one cycle", 1, 0);
      if (bus_rdy) begin
        if (q.size() == 0) check(1'b0, "R6 ready without access", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          if (e.rd) begin
            check(bus_rdata == e.data, "R3 read data", bus_rdata, e.data);
            last_rd = e.data;
          end else
            check(bus_rdata == last_rd, "R9 rdata kept on write", bus_rdata, last_rd);
        end
      end
    end
    prev_rdy = bus_rdy;
  end

  task automatic access(input bit rd, input int a, input logic [DATA_W-1:0] wd,
                        input int d, input bit hold, input bit disturb);
    int cyc;
    exp_t e;
    core_delay = d;
    e.rd = rd;
    e.data = rd ? shadow[a] : '0;
    if (!rd) shadow[a] = wd;
    q.push_back(e);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = wd; bus_rd = rd; bus_wr = !rd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc >= 2) begin
        bus_addr = ADDR_W'((a + cyc) % MEM_N); bus_wdata = ~wd;
        bus_rd = ~bus_rd; bus_wr = ~bus_wr;
      end
    end while (!bus_rdy && cyc < 100);
    if (rd) check(cyc == 4 + d, "R2 read latency", cyc, 4 + d);
    else    check(cyc == 4 + d, "R4 write latency", cyc, 4 + d);
    if (disturb) check(ack_addr == ADDR_W'(a), "R8 captured address", ack_addr, a);
    if (!hold) begin
      bus_rd = 1'b0; bus_wr = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = DATA_W'(16'h1000 + i * 16'h0101);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(bus_rdy == 0 && core_val == 0, "R1 reset outputs", {bus_rdy, core_val}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdy == 0 && core_val == 0, "R1 after reset", {bus_rdy, core_val}, 0);

    access(1, 2, '0, 0, 0, 0);
    access(1, 7, '0, 0, 0, 0);
    access(0, 5, 16'hBEEF, 0, 0, 0);
    access(1, 5, '0, 0, 0, 0);
    access(1, 9, '0, 2, 0, 0);
    access(0, 9, 16'h1234, 1, 0, 0);
    access(1, 9, '0, 0, 0, 0);

    // R4: write fields seen by the core while valid
    fork
      access(0, 3, 16'hA5A5, 1, 0, 0);
      begin
        @(posedge core_val);
        @(negedge clk);
        check(core_rd == 0 && core_addr == 3 && core_wdata == 16'hA5A5,
              "R4 write fields", {core_rd, core_addr, core_wdata}, {1'b0, 8'd3, 16'hA5A5});
      end
    join
    access(1, 3, '0, 0, 0, 0);

    // R7: strobe held high past ready
    access(1, 4, '0, 0, 1, 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (core_val || bus_rdy) bad++;
      end
      check(bad == 0, "R7 no access while strobe held", bad, 0);
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    access(1, 6, '0, 0, 0, 0);

    // R8: bus inputs change during a long core wait and at the ack edge
    access(1, 11, '0, 3, 0, 1);
    access(0, 12, 16'h7777, 2, 0, 1);
    access(1, 12, '0, 0, 0, 0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6 one ready per access", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule